// File: doc/BRIEF.md
# Two-Lane Router Output Port

This block is one output of a five-input wormhole router. Flits reach it from the five input ports. Route computation and crossbar steering are done upstream, so every flit presented here is bound for this output. The port holds two virtual lanes. A lane is claimed by the first flit of a packet and records the number of the input it then serves. That owner stays fixed until the packet's last flit has left on the link. While a lane is owned, only its owner can feed it. The two lanes take turns on the single outgoing link, so a packet stalled downstream on one lane does not stop a packet on the other lane.

Both edges are valid/ready. An input flit transfers when its `in_valid` and `in_ready` bits are both high at a clock edge. Each lane buffers one flit. A lane takes a new flit only when that buffer is empty or is being sent in the same cycle. On the link side, downstream gives one ready bit per lane. `out_valid` is raised only for a lane whose ready bit is high, and the flit on the link transfers in every cycle that `out_valid` is high. Flit kinds are encoded on 2 bits: Idle=0, Start=1, Body=2, End=3.

Top module: `vc_out_port`

## Requirements
- R1: During and just after reset, `out_valid` is 0, `vc_busy` is all 0 and every owner field of `vc_owner` is 0.
- R2: A Start flit (kind 1) from an input that holds no open lane is accepted when a lane is free. The lowest-numbered free lane is claimed. From the next cycle that lane's `vc_busy` bit is 1 and its owner field `vc_owner[v*3 +: 3]` holds the input number (0 to 4). The field stays unchanged while the lane is busy.
- R3: When several inputs present such Start flits in the same cycle, only the lowest-numbered of them sees `in_ready` high. At most one lane is claimed per cycle.
- R4: A Start flit that finds no free lane sees `in_ready` low and is not taken.
- R5: Once a lane is claimed, later non-Idle flits from its owner are accepted into that lane. A Body or End flit (kinds 2 and 3) from an input that owns no open lane sees `in_ready` low.
- R6: Each accepted flit appears on the link no earlier than the cycle after its acceptance. It carries unchanged data and kind, and `out_vc` gives the lane that carried it. Flits of one lane leave in the order they were accepted.
- R7: A lane whose `out_vc_ready` bit is low never sends. While it is blocked, the other lane keeps sending, so a later packet can overtake the blocked one.
- R8: When both lanes hold a flit and both ready bits are high, the link alternates between the lanes every cycle.
- R9: After a lane accepts an End flit, its owner gets no more flits into it. The lane's busy bit drops and its owner field returns to 0 in the cycle after that End flit is sent on the link.
- R10: Idle flits (kind 0) always see `in_ready` high and never appear on the link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 5 | Per-input flit valid |
| in_data | input | 40 | Per-input flit data, input i at bits [i*8 +: 8] |
| in_kind | input | 10 | Per-input flit kind, input i at bits [i*2 +: 2] |
| in_ready | output | 5 | Per-input flit accepted this cycle when valid |
| out_valid | output | 1 | Flit on link this cycle |
| out_vc | output | 1 | Lane carrying the link flit |
| out_data | output | 8 | Link flit data |
| out_kind | output | 2 | Link flit kind |
| out_vc_ready | input | 2 | Per-lane downstream ready |
| vc_busy | output | 2 | Per-lane claimed flag |
| vc_owner | output | 6 | Per-lane owning input, lane v at bits [v*3 +: 3] |

## Verification
The hardest situation to reach is one packet overtaking another: one lane must hold a full buffer behind a low ready bit while the other lane is claimed, filled and drained. The bench gets there by holding one lane's ready bit low across a whole packet on the other lane. It then checks that only the unblocked lane sends, and that the stalled packet leaves intact once ready returns. Strict alternation needs both buffers full at once. The bench fills them by claiming both lanes with both ready bits low, and then raises the ready bits together.

// File: rtl/vcop_pkg.sv
package vcop_pkg;
  typedef enum logic [1:0] {
    FL_IDLE  = 2'd0,
    FL_START = 2'd1,
    FL_BODY  = 2'd2,
    FL_END   = 2'd3
  } flit_kind_e;
endpackage

// File: rtl/vcop_lane.sv
// One virtual lane: owner record plus a single-flit holding buffer.
module vcop_lane
  import vcop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OWN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [OWN_W-1:0]  alloc_src_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  flit_kind_e        wr_kind_i,
  input  logic              sent_i,
  output logic              busy_o,
  output logic [OWN_W-1:0]  owner_o,
  output logic              open_o,
  output logic              full_o,
  output logic [DATA_W-1:0] hold_data_o,
  output flit_kind_e        hold_kind_o
);
  logic tail_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o      <= 1'b0;
      owner_o     <= '0;
      tail_seen   <= 1'b0;
      full_o      <= 1'b0;
      hold_data_o <= '0;
      hold_kind_o <= FL_IDLE;
    end else begin
      if (alloc_i) begin
        busy_o    <= 1'b1;
        owner_o   <= alloc_src_i;
        tail_seen <= 1'b0;
      end else if (sent_i && hold_kind_o == FL_END) begin
        busy_o    <= 1'b0;
        owner_o   <= '0;
        tail_seen <= 1'b0;
      end
      if (wr_i) begin
        full_o      <= 1'b1;
        hold_data_o <= wr_data_i;
        hold_kind_o <= wr_kind_i;
        if (wr_kind_i == FL_END) tail_seen <= 1'b1;
      end else if (sent_i) begin
        full_o <= 1'b0;
      end
    end
  end

  // A lane takes flits from its owner until the tail has been accepted.
  assign open_o = busy_o && !tail_seen;
endmodule

// File: rtl/vcop_alloc.sv
// Grants at most one free lane per cycle: lowest free lane, lowest requester.
module vcop_alloc #(
  parameter int NUM_IN = 5,
  parameter int NUM_VC = 2,
  parameter int OWN_W  = 3
) (
  input  logic [NUM_IN-1:0] start_req_i,
  input  logic [NUM_VC-1:0] vc_free_i,
  output logic [NUM_VC-1:0] alloc_vc_o,
  output logic [NUM_IN-1:0] grant_in_o,
  output logic [OWN_W-1:0]  grant_src_o
);
  logic vc_found;
  logic in_found;

  always_comb begin
    alloc_vc_o  = '0;
    grant_in_o  = '0;
    grant_src_o = '0;
    vc_found    = 1'b0;
    in_found    = 1'b0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (!in_found && start_req_i[i]) begin
        in_found    = 1'b1;
        grant_src_o = OWN_W'(i);
      end
    end
    for (int v = 0; v < NUM_VC; v++) begin
      if (in_found && !vc_found && vc_free_i[v]) begin
        vc_found      = 1'b1;
        alloc_vc_o[v] = 1'b1;
      end
    end
    if (vc_found) grant_in_o[grant_src_o] = 1'b1;
  end
endmodule

// File: rtl/vcop_link_arb.sv
// Rotating-priority pick among lanes that hold a flit and see ready.
module vcop_link_arb #(
  parameter int NUM_VC = 2,
  parameter int VC_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_VC-1:0] elig_i,
  output logic              any_o,
  output logic [VC_W-1:0]   pick_o
);
  logic [VC_W-1:0] last_q;

  always_comb begin
    any_o  = 1'b0;
    pick_o = '0;
    for (int k = 1; k <= NUM_VC; k++) begin
      int j;
      j = (int'(last_q) + k) % NUM_VC;
      if (!any_o && elig_i[j]) begin
        any_o  = 1'b1;
        pick_o = VC_W'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     last_q <= VC_W'(NUM_VC - 1);
    else if (any_o) last_q <= pick_o;
  end
endmodule

// File: rtl/vc_out_port.sv
module vc_out_port
  import vcop_pkg::*;
#(
  parameter int NUM_IN = 5,
  parameter int NUM_VC = 2,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IN-1:0]         in_valid,
  input  logic [NUM_IN*DATA_W-1:0]  in_data,
  input  logic [NUM_IN*2-1:0]       in_kind,
  output logic [NUM_IN-1:0]         in_ready,
  output logic                      out_valid,
  output logic [$clog2(NUM_VC)-1:0] out_vc,
  output logic [DATA_W-1:0]         out_data,
  output logic [1:0]                out_kind,
  input  logic [NUM_VC-1:0]         out_vc_ready,
  output logic [NUM_VC-1:0]         vc_busy,
  output logic [NUM_VC*$clog2(NUM_IN)-1:0] vc_owner
);
  localparam int VC_W  = $clog2(NUM_VC);
  localparam int OWN_W = $clog2(NUM_IN);

  logic [NUM_VC-1:0]              lane_open, lane_full, lane_wr, lane_sent, accept_ok;
  logic [NUM_VC-1:0][OWN_W-1:0]   lane_owner, sel_src;
  logic [NUM_VC-1:0][DATA_W-1:0]  lane_hold_data, lane_wr_data;
  flit_kind_e                     lane_hold_kind [NUM_VC];
  flit_kind_e                     lane_wr_kind   [NUM_VC];
  logic [NUM_VC-1:0]              lane_src_valid;
  logic [NUM_IN-1:0]              start_req, grant_in;
  logic [NUM_VC-1:0]              alloc_vc;
  logic [OWN_W-1:0]               grant_src;
  logic                           arb_any;
  logic [VC_W-1:0]                arb_pick;
  flit_kind_e                     kind_of [NUM_IN];

  always_comb begin
    for (int i = 0; i < NUM_IN; i++) kind_of[i] = flit_kind_e'(in_kind[i*2 +: 2]);
  end

  // Input-side decode: which lane (if any) each input is feeding.
  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      logic hit;
      logic ok;
      hit = 1'b0;
      ok  = 1'b0;
      for (int v = 0; v < NUM_VC; v++) begin
        if (lane_open[v] && lane_owner[v] == OWN_W'(i)) begin
          hit = 1'b1;
          ok  = accept_ok[v];
        end
      end
      start_req[i] = in_valid[i] && kind_of[i] == FL_START && !hit;
      if (kind_of[i] == FL_IDLE) in_ready[i] = 1'b1;
      else if (hit)              in_ready[i] = ok;
      else                       in_ready[i] = grant_in[i];
    end
  end

  vcop_alloc #(.NUM_IN(NUM_IN), .NUM_VC(NUM_VC), .OWN_W(OWN_W)) u_alloc (
    .start_req_i (start_req),
    .vc_free_i   (~vc_busy),
    .alloc_vc_o  (alloc_vc),
    .grant_in_o  (grant_in),
    .grant_src_o (grant_src)
  );

  vcop_link_arb #(.NUM_VC(NUM_VC), .VC_W(VC_W)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .elig_i (lane_full & out_vc_ready),
    .any_o  (arb_any),
    .pick_o (arb_pick)
  );

  for (genvar v = 0; v < NUM_VC; v++) begin : g_lane
    always_comb begin
      sel_src[v]        = alloc_vc[v] ? grant_src : lane_owner[v];
      lane_src_valid[v] = 1'b0;
      lane_wr_data[v]   = '0;
      lane_wr_kind[v]   = FL_IDLE;
      for (int i = 0; i < NUM_IN; i++) begin
        if (sel_src[v] == OWN_W'(i)) begin
          lane_src_valid[v] = in_valid[i];
          lane_wr_data[v]   = in_data[i*DATA_W +: DATA_W];
          lane_wr_kind[v]   = kind_of[i];
        end
      end
      lane_sent[v] = arb_any && arb_pick == VC_W'(v);
      accept_ok[v] = !lane_full[v] || lane_sent[v];
      lane_wr[v]   = alloc_vc[v] ||
                     (lane_open[v] && lane_src_valid[v] &&
                      lane_wr_kind[v] != FL_IDLE && accept_ok[v]);
    end

    vcop_lane #(.DATA_W(DATA_W), .OWN_W(OWN_W)) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_i     (alloc_vc[v]),
      .alloc_src_i (grant_src),
      .wr_i        (lane_wr[v]),
      .wr_data_i   (lane_wr_data[v]),
      .wr_kind_i   (lane_wr_kind[v]),
      .sent_i      (lane_sent[v]),
      .busy_o      (vc_busy[v]),
      .owner_o     (lane_owner[v]),
      .open_o      (lane_open[v]),
      .full_o      (lane_full[v]),
      .hold_data_o (lane_hold_data[v]),
      .hold_kind_o (lane_hold_kind[v])
    );

    assign vc_owner[v*OWN_W +: OWN_W] = lane_owner[v];
  end

  assign out_valid = arb_any;
  assign out_vc    = arb_pick;
  assign out_data  = lane_hold_data[arb_pick];
  assign out_kind  = lane_hold_kind[arb_pick];
endmodule

// File: rtl/vc_out_port_chk.sv
module vc_out_port_chk #(
  parameter int NUM_IN = 5,
  parameter int NUM_VC = 2,
  parameter int DATA_W = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      out_valid,
  input logic [$clog2(NUM_VC)-1:0] out_vc,
  input logic [1:0]                out_kind,
  input logic [NUM_VC-1:0]         out_vc_ready,
  input logic [NUM_VC-1:0]         vc_busy,
  input logic [NUM_VC*$clog2(NUM_IN)-1:0] vc_owner
);
  localparam int VC_W  = $clog2(NUM_VC);
  localparam int OWN_W = $clog2(NUM_IN);

  // R7: the link only carries a lane whose downstream ready is high.
  p_ready_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_vc_ready[out_vc]);

  // R10: Idle never reaches the link.
  p_no_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_kind != 2'd0);

  // R3: at most one lane is claimed per cycle.
  p_one_claim_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vc_busy & ~$past(vc_busy)) <= 1);

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    // R2: owner is fixed while the lane stays busy, and is a valid input.
    p_owner_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      vc_busy[v] |=> (!vc_busy[v] || $stable(vc_owner[v*OWN_W +: OWN_W])));
    p_owner_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      vc_busy[v] |-> vc_owner[v*OWN_W +: OWN_W] < OWN_W'(NUM_IN));
    // R9: sending the tail releases the lane on the next cycle.
    p_release_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_vc == VC_W'(v) && out_kind == 2'd3) |=> !vc_busy[v]);
    // R9: a free lane shows owner 0.
    p_free_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !vc_busy[v] |-> vc_owner[v*OWN_W +: OWN_W] == '0);
  end
endmodule

bind vc_out_port vc_out_port_chk #(
  .NUM_IN(NUM_IN), .NUM_VC(NUM_VC), .DATA_W(DATA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .out_valid    (out_valid),
  .out_vc       (out_vc),
  .out_kind     (out_kind),
  .out_vc_ready (out_vc_ready),
  .vc_busy      (vc_busy),
  .vc_owner     (vc_owner)
);

// File: tb/vc_out_port_bench.sv
`timescale 1ns/1ps
module vc_out_port_bench;
  localparam int NI = 5;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] iv;
  logic [DW-1:0] id [NI];
  logic [1:0]    ik [NI];
  logic [NI*DW-1:0] in_data;
  logic [NI*2-1:0]  in_kind;
  logic [NI-1:0] in_ready;
  logic          out_valid;
  logic [0:0]    out_vc;
  logic [DW-1:0] out_data;
  logic [1:0]    out_kind;
  logic [1:0]    out_vc_ready;
  logic [1:0]    vc_busy;
  logic [5:0]    vc_owner;
  int            n_run = 0;
  int            n_fail = 0;
  bit            done = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NI; i++) begin
      in_data[i*DW +: DW] = id[i];
      in_kind[i*2 +: 2]   = ik[i];
    end
  end

  vc_out_port u_vc_out_port (
    .clk(clk), .rst_n(rst_n), .in_valid(iv), .in_data(in_data), .in_kind(in_kind),
    .in_ready(in_ready), .out_valid(out_valid), .out_vc(out_vc), .out_data(out_data),
    .out_kind(out_kind), .out_vc_ready(out_vc_ready), .vc_busy(vc_busy), .vc_owner(vc_owner)
  );

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(int i, logic [1:0] k, logic [7:0] d);
    iv[i] = 1'b1; ik[i] = k; id[i] = d;
  endtask

  task automatic drop(int i);
    iv[i] = 1'b0; ik[i] = 2'd0; id[i] = '0;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic see(string req, int v, int d, int k);
    check({req, " out_valid"}, out_valid, 1);
    check({req, " out_vc"}, out_vc, v);
    check({req, " out_data"}, out_data, d);
    check({req, " out_kind"}, out_kind, k);
  endtask

  task automatic t_reset();
    check("R1 out_valid", out_valid, 0);
    check("R1 vc_busy", vc_busy, 0);
    check("R1 vc_owner", vc_owner, 0);
  endtask

  // R2 R5 R6 R9: one packet through lane 0.
  task automatic t_single();
    out_vc_ready = 2'b11;
    drive(3, 2'd1, 8'hA1); #6;
    check("R2 start ready", in_ready[3], 1);
    check("R6 not same cycle", out_valid, 0);
    tick();
    check("R2 busy", vc_busy, 1);
    check("R2 owner", vc_owner[2:0], 3);
    see("R6 start", 0, 8'hA1, 1);
    drive(3, 2'd2, 8'hB2); drive(1, 2'd2, 8'hC3); #6;
    check("R5 owner body ready", in_ready[3], 1);
    check("R5 stranger body ready", in_ready[1], 0);
    tick();
    drop(1);
    see("R6 body", 0, 8'hB2, 2);
    drive(3, 2'd3, 8'hE4); #6;
    check("R5 end ready", in_ready[3], 1);
    tick();
    see("R6 end", 0, 8'hE4, 3);
    check("R9 busy until sent", vc_busy, 1);
    drive(3, 2'd2, 8'h55); #6;
    check("R9 after tail ready", in_ready[3], 0);
    tick();
    drop(3);
    check("R9 released", vc_busy, 0);
    check("R9 owner cleared", vc_owner, 0);
    check("R9 nothing after tail", out_valid, 0);
  endtask

  // R3 R4 R8: contention for lanes, then alternation.
  task automatic t_contend();
    out_vc_ready = 2'b00;
    drive(1, 2'd1, 8'h11); drive(2, 2'd1, 8'h22); drive(4, 2'd1, 8'h44); #6;
    check("R3 lowest wins", in_ready[1], 1);
    check("R3 in2 waits", in_ready[2], 0);
    check("R3 in4 waits", in_ready[4], 0);
    tick();
    drop(1);
    check("R2 lane0 claimed", vc_busy, 1);
    check("R2 lane0 owner", vc_owner[2:0], 1);
    #4;
    check("R3 next lowest", in_ready[2], 1);
    check("R3 in4 still waits", in_ready[4], 0);
    tick();
    check("R2 both claimed", vc_busy, 3);
    check("R2 lane1 owner", vc_owner[5:3], 2);
    check("R4 no free lane", in_ready[4], 0);
    check("R7 both blocked", out_valid, 0);
    tick();
    check("R4 still refused", in_ready[4], 0);
    drop(4); drop(2);
    drive(1, 2'd3, 8'h1E); drive(2, 2'd3, 8'h2E); #4;
    check("R7 full lane0 refuses", in_ready[1], 0);
    check("R7 full lane1 refuses", in_ready[2], 0);
    out_vc_ready = 2'b11; #2;
    see("R8 first", 1, 8'h22, 1);
    check("R8 lane1 drains", in_ready[2], 1);
    check("R8 lane0 waits", in_ready[1], 0);
    tick();
    drop(2);
    see("R8 alt 2", 0, 8'h11, 1);
    check("R8 lane0 drains", in_ready[1], 1);
    tick();
    drop(1);
    see("R8 alt 3", 1, 8'h2E, 3);
    tick();
    see("R8 alt 4", 0, 8'h1E, 3);
    check("R9 lane1 freed", vc_busy, 1);
    tick();
    check("R9 both freed", vc_busy, 0);
    check("R6 drained", out_valid, 0);
  endtask

  // R7: lane 1 overtakes a blocked packet on lane 0.
  task automatic t_bypass();
    out_vc_ready = 2'b10;
    drive(0, 2'd1, 8'h01); #6;
    check("R7 claim ok", in_ready[0], 1);
    tick();
    check("R7 blocked lane silent", out_valid, 0);
    drive(0, 2'd2, 8'h02); drive(3, 2'd1, 8'h31); #6;
    check("R7 blocked lane refuses", in_ready[0], 0);
    check("R7 other claims", in_ready[3], 1);
    tick();
    see("R7 bypass start", 1, 8'h31, 1);
    drive(3, 2'd3, 8'h32);
    tick();
    drop(3);
    see("R7 bypass end", 1, 8'h32, 3);
    tick();
    check("R7 still blocked", out_valid, 0);
    check("R9 bypass lane freed", vc_busy, 1);
    out_vc_ready = 2'b11; #2;
    see("R7 resume start", 0, 8'h01, 1);
    check("R7 resume takes body", in_ready[0], 1);
    tick();
    see("R7 resume body", 0, 8'h02, 2);
    drive(0, 2'd3, 8'h03);
    tick();
    drop(0);
    see("R7 resume end", 0, 8'h03, 3);
    tick();
    check("R9 all free", vc_busy, 0);
  endtask

  // R10: Idle flits are swallowed.
  task automatic t_idle();
    drive(2, 2'd0, 8'h77); #6;
    check("R10 idle ready", in_ready[2], 1);
    tick();
    check("R10 idle not sent", out_valid, 0);
    check("R10 no claim", vc_busy, 0);
    drop(2);
  endtask

  initial begin
    iv = '0; out_vc_ready = 2'b11;
    for (int i = 0; i < NI; i++) begin id[i] = '0; ik[i] = '0; end
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_single();
    t_contend();
    t_bypass();
    t_idle();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule